// File: doc/BRIEF.md
# Packed Compare, OR and Shift Unit

This block is a one-stage 64-bit packed integer execution unit. It takes two 64-bit operands, an 8-bit immediate and a selector (the opcode byte that follows the 0F escape, plus the three-bit reg field of the mode byte), and produces one 64-bit result. It supports three kinds of work. The first is a signed greater-than compare over four 16-bit lanes that gives all-ones or all-zeros lane masks. The second is a full-width bitwise OR. The third is a set of lane shifts: logical left on 16-, 32- or 64-bit lanes, and arithmetic right on 32-bit lanes. The shift count comes either from the whole second operand or from the zero-extended immediate.

Operands enter on a valid/ready stream, and results leave on a valid/ready stream. One output register sits between the two. The input side is ready whenever the output register is empty, or when its content is being taken in the same cycle. This gives one result per clock when the consumer never stalls. When the consumer holds `res_ready` low while a result is pending, the result stays frozen and new input is refused. A selector that is not defined gives a zero result with the `res_illegal` flag set. That result is carried through the same stream.

Top module: `packed_cs_unit`

## Requirements
- R1: Selector byte 0x65 compares each 16-bit lane of `op_a` with the same lane of `op_b` as signed two's-complement numbers. A result lane is 0xFFFF when the `op_a` lane is strictly greater, and 0x0000 otherwise (equal values give 0x0000).
- R2: Selector byte 0xEB gives the 64-bit bitwise OR of `op_a` and `op_b`.
- R3: Selector bytes 0xF1, 0xF2 and 0xF3 shift every lane of `op_a` left, filling with zeros. The lanes are 16-bit, 32-bit and 64-bit lanes respectively. The count is the whole 64-bit `op_b`.
- R4: A left shift whose unsigned count is at least the lane width clears the lane. This includes counts whose only set bits lie above bit 31 of `op_b`.
- R5: Selector byte 0xE2 shifts each 32-bit lane of `op_a` right arithmetically by the 64-bit count in `op_b`, filling with the lane's sign bit. Any count of 32 or more fills the lane with its sign.
- R6: The immediate-count forms are selector bytes 0x71, 0x72 and 0x73 (16-, 32- and 64-bit lanes) with mode reg field 3'b110 for a left shift. Selector byte 0x72 with reg field 3'b100 gives a 32-bit arithmetic right shift. The count is `sel_imm` zero-extended, and `op_b` has no effect.
- R7: Any other selector gives a zero result with `res_illegal` = 1. This includes 0x71 or 0x73 with reg field 3'b100, and 0x71, 0x72 or 0x73 with any reg field other than 3'b110 or 3'b100. Defined selectors give `res_illegal` = 0. The reg field is ignored for the register-count forms.
- R8: An operand accepted on a clock edge (`op_valid` && `op_ready`) appears on `res_data` and `res_illegal` with `res_valid` = 1 right after that edge. Results leave in acceptance order.
- R9: `op_ready` = !`res_valid` || `res_ready`. While `res_valid` = 1 and `res_ready` = 0, `res_data`, `res_illegal` and `res_valid` hold their values.
- R10: After reset, `res_valid`, `res_data` and `res_illegal` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | Operand beat present |
| op_ready | output | 1 | Unit can take an operand beat |
| sel_opc | input | 8 | Opcode byte after the 0F escape |
| sel_reg | input | 3 | Reg field of the mode byte (immediate forms) |
| sel_imm | input | 8 | Immediate shift count |
| op_a | input | 64 | First operand, and the value that is shifted |
| op_b | input | 64 | Second operand, or the register shift count |
| res_valid | output | 1 | Result beat present |
| res_ready | input | 1 | Consumer takes the result beat |
| res_data | output | 64 | Result value |
| res_illegal | output | 1 | Selector was undefined |

## Verification
The only state is the output register and its valid bit, so any corrupt state is visible at the ports within one clock. A wrong decode or lane split shows as a bad `res_data` on the first result beat after acceptance. A lost or duplicated valid bit shows as a missing, extra or reordered beat against the expected-result queue. A register that fails to hold under back-pressure shows as a changed `res_data` during the stall, in the same cycle the change happens. Counts at exactly the lane width, and counts set only above bit 31, are the points where a truncated count compare would first go wrong.

// File: rtl/pcs_pkg.sv
package pcs_pkg;
  typedef enum logic [2:0] {
    OP_NONE  = 3'd0,
    OP_CMPGT = 3'd1,
    OP_OR    = 3'd2,
    OP_SHL   = 3'd3,
    OP_SRA   = 3'd4
  } pcs_op_e;

  typedef enum logic [1:0] {
    LANE_W16 = 2'd0,
    LANE_W32 = 2'd1,
    LANE_W64 = 2'd2
  } pcs_lane_e;

  typedef struct packed {
    pcs_op_e   op;
    pcs_lane_e lane;
    logic      use_imm;
    logic      illegal;
  } pcs_ctl_t;

  localparam logic [7:0] OPC_CMPGT_W = 8'h65;
  localparam logic [7:0] OPC_OR_Q    = 8'hEB;
  localparam logic [7:0] OPC_SHL_W   = 8'hF1;
  localparam logic [7:0] OPC_SHL_D   = 8'hF2;
  localparam logic [7:0] OPC_SHL_Q   = 8'hF3;
  localparam logic [7:0] OPC_SRA_D   = 8'hE2;
  localparam logic [7:0] OPC_IMM_W   = 8'h71;
  localparam logic [7:0] OPC_IMM_D   = 8'h72;
  localparam logic [7:0] OPC_IMM_Q   = 8'h73;
  localparam logic [2:0] REG_SHL     = 3'b110;
  localparam logic [2:0] REG_SRA     = 3'b100;
endpackage

// File: rtl/pcs_decode.sv
module pcs_decode
  import pcs_pkg::*;
(
  input  logic [7:0] opc,
  input  logic [2:0] mreg,
  output pcs_ctl_t   ctl
);
  always_comb begin
    ctl = '{op: OP_NONE, lane: LANE_W16, use_imm: 1'b0, illegal: 1'b1};
    unique case (opc)
      OPC_CMPGT_W: ctl = '{op: OP_CMPGT, lane: LANE_W16, use_imm: 1'b0, illegal: 1'b0};
      OPC_OR_Q:    ctl = '{op: OP_OR,    lane: LANE_W64, use_imm: 1'b0, illegal: 1'b0};
      OPC_SHL_W:   ctl = '{op: OP_SHL,   lane: LANE_W16, use_imm: 1'b0, illegal: 1'b0};
      OPC_SHL_D:   ctl = '{op: OP_SHL,   lane: LANE_W32, use_imm: 1'b0, illegal: 1'b0};
      OPC_SHL_Q:   ctl = '{op: OP_SHL,   lane: LANE_W64, use_imm: 1'b0, illegal: 1'b0};
      OPC_SRA_D:   ctl = '{op: OP_SRA,   lane: LANE_W32, use_imm: 1'b0, illegal: 1'b0};
      OPC_IMM_W: if (mreg == REG_SHL)
        ctl = '{op: OP_SHL, lane: LANE_W16, use_imm: 1'b1, illegal: 1'b0};
      OPC_IMM_D: begin
        if (mreg == REG_SHL)
          ctl = '{op: OP_SHL, lane: LANE_W32, use_imm: 1'b1, illegal: 1'b0};
        else if (mreg == REG_SRA)
          ctl = '{op: OP_SRA, lane: LANE_W32, use_imm: 1'b1, illegal: 1'b0};
      end
      OPC_IMM_Q: if (mreg == REG_SHL)
        ctl = '{op: OP_SHL, lane: LANE_W64, use_imm: 1'b1, illegal: 1'b0};
      default: ;
    endcase
  end
endmodule

// File: rtl/pcs_cmp.sv
module pcs_cmp #(
  parameter int DATA_W = 64,
  parameter int LANE_W = 16
) (
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  output logic [DATA_W-1:0] mask
);
  localparam int LANES = DATA_W / LANE_W;

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic gt;
    assign gt = $signed(a[l*LANE_W +: LANE_W]) > $signed(b[l*LANE_W +: LANE_W]);
    assign mask[l*LANE_W +: LANE_W] = {LANE_W{gt}};
  end
endmodule

// File: rtl/pcs_shift.sv
module pcs_shift
  import pcs_pkg::*;
#(
  parameter int DATA_W = 64,
  parameter int MIN_W  = 16
) (
  input  logic [DATA_W-1:0] src,
  input  logic [DATA_W-1:0] cnt,
  input  pcs_lane_e         lane,
  input  logic              arith,
  output logic [DATA_W-1:0] res
);
  localparam int NVAR = 3;
  localparam int SRA_K = 1;

  logic [NVAR-1:0][DATA_W-1:0] shl_res;
  logic [DATA_W-1:0]           sra_res;

  for (genvar k = 0; k < NVAR; k++) begin : g_width
    localparam int LW    = MIN_W << k;
    localparam int SH_W  = $clog2(LW);
    localparam int LANES = DATA_W / LW;
    logic sat;
    assign sat = |cnt[DATA_W-1:SH_W];
    for (genvar l = 0; l < LANES; l++) begin : g_lane
      logic [LW-1:0] v;
      assign v = src[l*LW +: LW];
      assign shl_res[k][l*LW +: LW] = sat ? '0 : (v << cnt[SH_W-1:0]);
      if (k == SRA_K) begin : g_sra
        assign sra_res[l*LW +: LW] = sat ? {LW{v[LW-1]}}
                                         : LW'($signed(v) >>> cnt[SH_W-1:0]);
      end
    end
  end

  always_comb begin
    if (arith) res = sra_res;
    else begin
      unique case (lane)
        LANE_W16: res = shl_res[0];
        LANE_W32: res = shl_res[1];
        default:  res = shl_res[2];
      endcase
    end
  end
endmodule

// File: rtl/packed_cs_unit.sv
module packed_cs_unit
  import pcs_pkg::*;
#(
  parameter int DATA_W = 64,
  parameter int WORD_W = 16,
  parameter int IMM_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              op_valid,
  output logic              op_ready,
  input  logic [7:0]        sel_opc,
  input  logic [2:0]        sel_reg,
  input  logic [IMM_W-1:0]  sel_imm,
  input  logic [DATA_W-1:0] op_a,
  input  logic [DATA_W-1:0] op_b,
  output logic              res_valid,
  input  logic              res_ready,
  output logic [DATA_W-1:0] res_data,
  output logic              res_illegal
);
  pcs_ctl_t          ctl;
  logic [DATA_W-1:0] cnt;
  logic [DATA_W-1:0] cmp_res;
  logic [DATA_W-1:0] sh_res;
  logic [DATA_W-1:0] nxt;
  logic              accept;
  logic              vld_q;
  logic              ill_q;
  logic [DATA_W-1:0] dat_q;

  pcs_decode u_dec (.opc(sel_opc), .mreg(sel_reg), .ctl(ctl));

  assign cnt = ctl.use_imm ? {{(DATA_W-IMM_W){1'b0}}, sel_imm} : op_b;

  pcs_cmp #(.DATA_W(DATA_W), .LANE_W(WORD_W)) u_cmp (
    .a(op_a), .b(op_b), .mask(cmp_res));

  pcs_shift #(.DATA_W(DATA_W), .MIN_W(WORD_W)) u_sh (
    .src(op_a), .cnt(cnt), .lane(ctl.lane),
    .arith(ctl.op == OP_SRA), .res(sh_res));

  always_comb begin
    unique case (ctl.op)
      OP_CMPGT:       nxt = cmp_res;
      OP_OR:          nxt = op_a | op_b;
      OP_SHL, OP_SRA: nxt = sh_res;
      default:        nxt = '0;
    endcase
  end

  assign op_ready = !vld_q || res_ready;
  assign accept   = op_valid && op_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld_q <= 1'b0;
      ill_q <= 1'b0;
      dat_q <= '0;
    end else if (accept) begin
      vld_q <= 1'b1;
      ill_q <= ctl.illegal;
      dat_q <= nxt;
    end else if (res_ready) begin
      vld_q <= 1'b0;
    end
  end

  assign res_valid   = vld_q;
  assign res_illegal = ill_q;
  assign res_data    = dat_q;
endmodule

// File: rtl/pcs_unit_checker.sv
module pcs_unit_checker #(
  parameter int DATA_W = 64
) (
  input logic              clk,
  input logic              rst_n,
  input logic              op_valid,
  input logic              op_ready,
  input logic [7:0]        sel_opc,
  input logic [DATA_W-1:0] op_a,
  input logic [DATA_W-1:0] op_b,
  input logic              res_valid,
  input logic              res_ready,
  input logic [DATA_W-1:0] res_data,
  input logic              res_illegal
);
  logic acc;
  assign acc = op_valid && op_ready;

  assert_accept_gives_result_R8: assert property (@(posedge clk) disable iff (!rst_n)
    acc |=> res_valid);

  assert_stall_holds_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_ready) |=> (res_valid && $stable(res_data) && $stable(res_illegal)));

  assert_empty_is_ready_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !res_valid |-> op_ready);

  assert_illegal_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && res_illegal) |-> (res_data == '0));

  assert_or_result_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && sel_opc == 8'hEB) |=> (res_data == ($past(op_a) | $past(op_b)) && !res_illegal));

  assert_cmp_masks_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && sel_opc == 8'h65) |=>
      ((res_data[15:0]  == 16'h0 || res_data[15:0]  == 16'hFFFF) &&
       (res_data[31:16] == 16'h0 || res_data[31:16] == 16'hFFFF) &&
       (res_data[47:32] == 16'h0 || res_data[47:32] == 16'hFFFF) &&
       (res_data[63:48] == 16'h0 || res_data[63:48] == 16'hFFFF)));
endmodule

bind packed_cs_unit pcs_unit_checker #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_ready(op_ready),
  .sel_opc(sel_opc), .op_a(op_a), .op_b(op_b), .res_valid(res_valid),
  .res_ready(res_ready), .res_data(res_data), .res_illegal(res_illegal));

// File: tb/packed_cs_unit_tb.sv
module packed_cs_unit_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        op_valid = 1'b0;
  logic        op_ready;
  logic [7:0]  sel_opc = '0;
  logic [2:0]  sel_reg = '0;
  logic [7:0]  sel_imm = '0;
  logic [63:0] op_a = '0;
  logic [63:0] op_b = '0;
  logic        res_valid;
  logic        res_ready = 1'b1;
  logic [63:0] res_data;
  logic        res_illegal;

  int n_run = 0;
  int n_fail = 0;
  int cycles = 0;
  bit prev_acc = 1'b0;
  logic [64:0] expq[$];
  string       tagq[$];

  always #10 clk = ~clk;

  packed_cs_unit dut_i (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_ready(op_ready),
    .sel_opc(sel_opc), .sel_reg(sel_reg), .sel_imm(sel_imm),
    .op_a(op_a), .op_b(op_b), .res_valid(res_valid), .res_ready(res_ready),
    .res_data(res_data), .res_illegal(res_illegal));

  function automatic string tag_of(logic [7:0] o, logic [2:0] r);
    case (o)
      8'h65: return "R1";
      8'hEB: return "R2";
      8'hF1, 8'hF2, 8'hF3: return "R3/R4";
      8'hE2: return "R5";
      8'h71, 8'h73: return (r == 3'b110) ? "R6" : "R7";
      8'h72: return (r == 3'b110 || r == 3'b100) ? "R6" : "R7";
      default: return "R7";
    endcase
  endfunction

  // behavioural reference: {illegal, data}
  function automatic logic [64:0] ref_op(logic [7:0] o, logic [2:0] r,
                                         logic [63:0] a, logic [63:0] b, logic [7:0] imm);
    logic [63:0] y = '0;
    longint unsigned c;
    int lw = 0;
    bit arith = 0;
    bit imm_form = 0;
    case (o)
      8'h65: begin
        for (int i = 0; i < 4; i++)
          if ($signed(a[i*16 +: 16]) > $signed(b[i*16 +: 16])) y[i*16 +: 16] = 16'hFFFF;
        return {1'b0, y};
      end
      8'hEB: return {1'b0, a | b};
      8'hF1: lw = 16;
      8'hF2: lw = 32;
      8'hF3: lw = 64;
      8'hE2: begin lw = 32; arith = 1; end
      8'h71: if (r == 3'b110) begin lw = 16; imm_form = 1; end
      8'h72: if (r == 3'b110) begin lw = 32; imm_form = 1; end
             else if (r == 3'b100) begin lw = 32; arith = 1; imm_form = 1; end
      8'h73: if (r == 3'b110) begin lw = 64; imm_form = 1; end
      default: ;
    endcase
    if (lw == 0) return {1'b1, 64'h0};
    c = imm_form ? longint'(imm) : b;
    if (c > 64) c = 64;
    for (int j = 0; j < 64; j++) begin
      int base = j - (j % lw);
      int pos = j % lw;
      int src;
      if (arith) begin
        src = pos + int'(c);
        y[j] = (src < lw) ? a[base + src] : a[base + lw - 1];
      end else begin
        src = pos - int'(c);
        y[j] = (src >= 0) ? a[base + src] : 1'b0;
      end
    end
    return {1'b0, y};
  endfunction

  task automatic check(bit ok, string tag, string what, logic [64:0] act, logic [64:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic step(bit v, logic [7:0] o, logic [2:0] r, logic [63:0] a,
                      logic [63:0] b, logic [7:0] imm, bit rdy);
    @(negedge clk);
    op_valid = v; sel_opc = o; sel_reg = r; op_a = a; op_b = b; sel_imm = imm;
    res_ready = rdy;
    #1;
    if (prev_acc) check(res_valid === 1'b1, "R8", "valid after accept", 65'(res_valid), 65'd1);
    check(op_ready === (!res_valid || res_ready), "R9", "op_ready rule",
          65'(op_ready), 65'(!res_valid || res_ready));
    if (res_valid) begin
      if (expq.size() == 0) check(1'b0, "R8", "unexpected result", {res_illegal, res_data}, '0);
      else begin
        check({res_illegal, res_data} === expq[0], tagq[0], "result",
              {res_illegal, res_data}, expq[0]);
        if (res_ready) begin void'(expq.pop_front()); void'(tagq.pop_front()); end
      end
    end
    prev_acc = v && op_ready;
    if (prev_acc) begin
      expq.push_back(ref_op(o, r, a, b, imm));
      tagq.push_back(tag_of(o, r));
    end
  endtask

  task automatic go(logic [7:0] o, logic [2:0] r, logic [63:0] a, logic [63:0] b, logic [7:0] imm);
    step(1'b1, o, r, a, b, imm, 1'b1);
  endtask

  initial begin : watchdog
    while (cycles < 100000) begin @(posedge clk); cycles++; end
    n_run++; n_fail++;
    $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin : main
    logic [7:0] opl[10] = '{8'h65, 8'hEB, 8'hF1, 8'hF2, 8'hF3, 8'hE2, 8'h71, 8'h72, 8'h73, 8'h00};
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    check(res_valid === 1'b0 && res_data === '0 && res_illegal === 1'b0, "R10", "reset state",
          {res_illegal, res_data}, '0);
    // R1 signed compare corners
    go(8'h65, 3'd0, 64'h7FFF_0001_8000_FFFF, 64'h8000_0001_7FFF_FFFE, 8'd0);
    go(8'h65, 3'd5, 64'h0000_FFFF_1234_0005, 64'h0000_0000_1233_0006, 8'd0);
    // R2
    go(8'hEB, 3'd0, 64'hF0F0_0000_1234_0001, 64'h0F0F_8000_4321_0100, 8'd0);
    // R3 / R4 register-count left shifts
    go(8'hF1, 3'd0, 64'h8001_4002_2004_1008, 64'd1, 8'd0);
    go(8'hF1, 3'd0, 64'hFFFF_FFFF_FFFF_FFFF, 64'd15, 8'd0);
    go(8'hF1, 3'd0, 64'hFFFF_FFFF_FFFF_FFFF, 64'd16, 8'd0);
    go(8'hF2, 3'd0, 64'h8000_0001_1234_5678, 64'd31, 8'd0);
    go(8'hF2, 3'd0, 64'h8000_0001_1234_5678, 64'd32, 8'd0);
    go(8'hF3, 3'd0, 64'h0123_4567_89AB_CDEF, 64'd63, 8'd0);
    go(8'hF3, 3'd0, 64'h0123_4567_89AB_CDEF, 64'd64, 8'd0);
    go(8'hF3, 3'd0, 64'h0123_4567_89AB_CDEF, 64'h0000_0001_0000_0001, 8'd0);
    go(8'hF1, 3'd0, 64'h1111_2222_3333_4444, 64'h8000_0000_0000_0000, 8'd0);
    // R5 arithmetic right dword
    go(8'hE2, 3'd0, 64'h8000_0000_7FFF_FFFF, 64'd4, 8'd0);
    go(8'hE2, 3'd0, 64'h8000_0000_7FFF_FFFF, 64'd31, 8'd0);
    go(8'hE2, 3'd0, 64'h8000_0000_7FFF_FFFF, 64'd32, 8'd0);
    go(8'hE2, 3'd0, 64'hF000_1234_0FFF_0000, 64'h0000_0002_0000_0000, 8'd0);
    // R6 immediate forms, op_b ignored
    go(8'h71, 3'b110, 64'h0001_0002_0004_8008, 64'hFFFF_FFFF_FFFF_FFFF, 8'd3);
    go(8'h72, 3'b110, 64'h0001_0002_0004_8008, 64'hFFFF_FFFF_FFFF_FFFF, 8'd31);
    go(8'h73, 3'b110, 64'h0001_0002_0004_8008, 64'd0, 8'd200);
    go(8'h72, 3'b100, 64'h8765_4321_7654_3210, 64'd0, 8'd8);
    go(8'h72, 3'b100, 64'h8765_4321_7654_3210, 64'd1, 8'd255);
    // R7 undefined selectors
    go(8'h00, 3'd0, 64'hFFFF, 64'hFFFF, 8'd1);
    go(8'h71, 3'b100, 64'hFFFF, 64'hFFFF, 8'd1);
    go(8'h73, 3'b100, 64'hFFFF, 64'hFFFF, 8'd1);
    go(8'h72, 3'b010, 64'hFFFF, 64'hFFFF, 8'd1);
    // R8 / R9 random traffic with back-pressure
    for (int i = 0; i < 600; i++) begin
      logic [7:0]  o = opl[$urandom_range(0, 9)];
      logic [2:0]  r = ($urandom_range(0, 3) == 0) ? 3'($urandom) :
                       (($urandom_range(0, 1) == 0) ? 3'b110 : 3'b100);
      logic [63:0] a = {$urandom, $urandom};
      logic [63:0] b = ($urandom_range(0, 3) == 0) ? {$urandom, $urandom}
                                                   : 64'($urandom_range(0, 70));
      step($urandom_range(0, 4) != 0, o, r, a, b, 8'($urandom_range(0, 80)),
           $urandom_range(0, 9) < 7);
    end
    for (int i = 0; i < 20 && expq.size() != 0; i++) step(1'b0, 8'h0, 3'd0, '0, '0, '0, 1'b1);
    step(1'b0, 8'h0, 3'd0, '0, '0, '0, 1'b1);
    check(expq.size() == 0 && res_valid === 1'b0, "R8", "drained", 65'(expq.size()), 65'd0);
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule